// File: doc/BRIEF.md
# Rotating Offset Register Loader

This block holds the two programmable-flag thresholds of one FIFO channel: an empty offset and a full offset. Each threshold is split into a low part and a high part, so there are four small registers. Software reaches them through the channel's own data input and write/read enables, not through an address bus. When load access is selected, each write access stores the data word into the register picked by a two-bit write selector. The selector then moves on to the next register in a fixed rotation. Read accesses use a second, independent selector with the same rotation and return the selected register on a readback port.

A shared control pin has two possible meanings, and the value it holds during reset chooses one. Held low during reset, it becomes an active-low load strobe for the offset registers. Held high during reset, it becomes an active-high second write enable for the FIFO. The block also produces the qualified FIFO write and read strobes, so writes and reads reach FIFO storage only when they are not aimed at the offset registers. The assembled offsets go to the flag logic. A read and a write that target the offset registers in the same cycle are a usage error: the write is done, the read is dropped, and an error pulse is raised.

Top module: `ofs_loader`

## Requirements
- R1: After reset, both offsets equal 7 (low part 7, high part 0), `rd_data_o` is 0, `coll_err_o` is 0, and both selectors point at the empty-offset low register.
- R2: The level of `shared_ctl_i` sampled at clock edges while `rst_ni` is low fixes the mode until the next reset: low selects load mode, high selects second-enable mode.
- R3: In load mode, a rising clock edge with `wen_ni` low and `shared_ctl_i` low writes into the register the write selector points at, and the selector then advances. The rotation is empty-low (0), empty-high (1), full-low (2), full-high (3), then back to 0. `empty_ofs_o` and `full_ofs_o` equal {high part, low part}.
- R4: A low register takes `data_i[LO_W-1:0]`. A high register stores only `data_i[OW-LO_W-1:0]`, its other data bits are dropped, and readback bits above each register's width are 0.
- R5: In load mode, `fifo_we_o` = `!wen_ni && shared_ctl_i`. With `wen_ni` high, nothing is written and the write selector does not move.
- R6: In load mode, a rising edge with `ren1_ni`, `ren2_ni` and `shared_ctl_i` all low puts the register the read selector points at onto `rd_data_o` (valid after that edge). The read selector advances in the same rotation as the write selector but independently of it, and `rd_data_o` holds its value between read accesses.
- R7: If an offset write and an offset read fall on the same edge, the write completes, the read selector does not move, `rd_data_o` is unchanged, and `coll_err_o` is high for the following cycle only.
- R8: In second-enable mode, no input pattern changes the offsets or `rd_data_o`. Here `fifo_we_o` = `!wen_ni && shared_ctl_i` and `fifo_re_o` = `!ren1_ni && !ren2_ni`.
- R9: In load mode, `fifo_re_o` = `!ren1_ni && !ren2_ni && shared_ctl_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by the write and read access paths |
| rst_ni | input | 1 | Asynchronous active-low reset |
| shared_ctl_i | input | 1 | Load strobe (active low) or second write enable (active high), chosen at reset |
| wen_ni | input | 1 | Active-low write enable |
| ren1_ni | input | 1 | First active-low read enable |
| ren2_ni | input | 1 | Second active-low read enable |
| data_i | input | DATA_W | Data word, also the offset load value |
| fifo_we_o | output | 1 | Qualified FIFO write strobe |
| fifo_re_o | output | 1 | Qualified FIFO read strobe |
| rd_data_o | output | DATA_W | Offset readback, zero-extended |
| empty_ofs_o | output | OW | Assembled empty offset |
| full_ofs_o | output | OW | Assembled full offset |
| coll_err_o | output | 1 | One-cycle pulse after a simultaneous offset read and write |

## Verification
The bench uses the defaults: OW = 11, LO_W = 8 and DATA_W = 9, which gives 3-bit high registers. With these values, a written high word whose upper data bits are set shows that those bits are truncated. The 9-bit readback also exposes the zero bits above both the 8-bit low registers and the 3-bit high registers. Both selectors go past the end of the rotation, so the wrap back to the empty-low position is checked for writes and for reads.

// File: rtl/ofs_loader_pkg.sv
package ofs_loader_pkg;
  typedef enum logic [1:0] {
    SEL_E_LO = 2'd0,
    SEL_E_HI = 2'd1,
    SEL_F_LO = 2'd2,
    SEL_F_HI = 2'd3
  } ofs_sel_e;

  function automatic ofs_sel_e next_sel(ofs_sel_e s);
    return ofs_sel_e'(s + 2'd1);
  endfunction
endpackage

// File: rtl/ofs_ctl_decode.sv
module ofs_ctl_decode (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic shared_ctl_i,
  input  logic wen_ni,
  input  logic ren1_ni,
  input  logic ren2_ni,
  output logic load_mode_o,
  output logic ofs_wr_o,
  output logic ofs_rd_o,
  output logic coll_o,
  output logic fifo_we_o,
  output logic fifo_re_o
);
  logic mode_q;
  logic ld_act, wr_req, rd_req;

  // mode follows the pin level while reset is held (clock runs during reset)
  always_ff @(posedge clk_i) begin
    if (!rst_ni) mode_q <= ~shared_ctl_i;
  end

  assign load_mode_o = mode_q;
  assign ld_act      = mode_q & ~shared_ctl_i;
  assign wr_req      = ~wen_ni;
  assign rd_req      = ~ren1_ni & ~ren2_ni;

  assign ofs_wr_o  = rst_ni & ld_act & wr_req;
  assign coll_o    = rst_ni & ld_act & wr_req & rd_req;
  assign ofs_rd_o  = rst_ni & ld_act & rd_req & ~wr_req;
  assign fifo_we_o = wr_req & shared_ctl_i;
  assign fifo_re_o = rd_req & ~ld_act;
endmodule

// File: rtl/ofs_sel_ctr.sv
module ofs_sel_ctr
  import ofs_loader_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     adv_i,
  output ofs_sel_e sel_o
);
  ofs_sel_e sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sel_q <= SEL_E_LO;
    else if (adv_i) sel_q <= next_sel(sel_q);
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/ofs_reg_bank.sv
module ofs_reg_bank
  import ofs_loader_pkg::*;
#(
  parameter int unsigned OW      = 11,
  parameter int unsigned LO_W    = 8,
  parameter int unsigned DATA_W  = 9,
  parameter int unsigned RST_OFS = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  ofs_sel_e          wsel_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  ofs_sel_e          rsel_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [OW-1:0]     empty_ofs_o,
  output logic [OW-1:0]     full_ofs_o
);
  localparam int unsigned HI_W = OW - LO_W;
  localparam logic [OW-1:0] RST_V = OW'(RST_OFS);

  logic [2*LO_W-1:0] lo_all;
  logic [2*HI_W-1:0] hi_all;

  // g = 0: empty offset, g = 1: full offset
  for (genvar g = 0; g < 2; g++) begin : g_ofs
    logic [LO_W-1:0] lo_q;
    logic [HI_W-1:0] hi_q;
    logic            wr_lo, wr_hi;

    assign wr_lo = wr_i && (wsel_i == ofs_sel_e'({g[0], 1'b0}));
    assign wr_hi = wr_i && (wsel_i == ofs_sel_e'({g[0], 1'b1}));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_q <= RST_V[LO_W-1:0];
        hi_q <= RST_V[OW-1:LO_W];
      end else begin
        if (wr_lo) lo_q <= wdata_i[LO_W-1:0];
        if (wr_hi) hi_q <= wdata_i[HI_W-1:0];
      end
    end

    assign lo_all[g*LO_W +: LO_W] = lo_q;
    assign hi_all[g*HI_W +: HI_W] = hi_q;
  end

  assign empty_ofs_o = {hi_all[0 +: HI_W], lo_all[0 +: LO_W]};
  assign full_ofs_o  = {hi_all[HI_W +: HI_W], lo_all[LO_W +: LO_W]};

  always_comb begin
    rdata_o = '0;
    if (rsel_i[0]) rdata_o[HI_W-1:0] = rsel_i[1] ? hi_all[HI_W +: HI_W] : hi_all[0 +: HI_W];
    else           rdata_o[LO_W-1:0] = rsel_i[1] ? lo_all[LO_W +: LO_W] : lo_all[0 +: LO_W];
  end
endmodule

// File: rtl/ofs_loader.sv
module ofs_loader
  import ofs_loader_pkg::*;
#(
  parameter int unsigned OW      = 11,
  parameter int unsigned LO_W    = 8,
  parameter int unsigned DATA_W  = 9,
  parameter int unsigned RST_OFS = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shared_ctl_i,
  input  logic              wen_ni,
  input  logic              ren1_ni,
  input  logic              ren2_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic              fifo_we_o,
  output logic              fifo_re_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [OW-1:0]     empty_ofs_o,
  output logic [OW-1:0]     full_ofs_o,
  output logic              coll_err_o
);
  logic              load_mode, ofs_wr, ofs_rd, coll;
  ofs_sel_e          wsel, rsel;
  logic [DATA_W-1:0] rmux;
  logic [DATA_W-1:0] rd_q;
  logic              coll_q;

  ofs_ctl_decode u_dec (
    .clk_i, .rst_ni, .shared_ctl_i, .wen_ni, .ren1_ni, .ren2_ni,
    .load_mode_o(load_mode), .ofs_wr_o(ofs_wr), .ofs_rd_o(ofs_rd),
    .coll_o(coll), .fifo_we_o, .fifo_re_o
  );

  ofs_sel_ctr u_wsel (.clk_i, .rst_ni, .adv_i(ofs_wr), .sel_o(wsel));
  ofs_sel_ctr u_rsel (.clk_i, .rst_ni, .adv_i(ofs_rd), .sel_o(rsel));

  ofs_reg_bank #(.OW(OW), .LO_W(LO_W), .DATA_W(DATA_W), .RST_OFS(RST_OFS)) u_bank (
    .clk_i, .rst_ni, .wr_i(ofs_wr), .wsel_i(wsel), .wdata_i(data_i),
    .rsel_i(rsel), .rdata_o(rmux), .empty_ofs_o, .full_ofs_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= '0;
      coll_q <= 1'b0;
    end else begin
      if (ofs_rd) rd_q <= rmux;
      coll_q <= coll;
    end
  end

  assign rd_data_o  = rd_q;
  assign coll_err_o = coll_q;
endmodule

// File: rtl/ofs_loader_chk.sv
module ofs_loader_chk #(
  parameter int unsigned OW     = 11,
  parameter int unsigned LO_W   = 8,
  parameter int unsigned DATA_W = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              shared_ctl_i,
  input logic              wen_ni,
  input logic              ren1_ni,
  input logic              ren2_ni,
  input logic              fifo_we_o,
  input logic              fifo_re_o,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [OW-1:0]     empty_ofs_o,
  input logic [OW-1:0]     full_ofs_o,
  input logic              coll_err_o,
  input logic              load_mode_i
);
  logic ld_act;
  assign ld_act = load_mode_i && !shared_ctl_i;

  a_r5_no_fifo_we_on_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_act |-> !fifo_we_o);

  a_r9_no_fifo_re_on_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_act |-> !fifo_re_o);

  a_r3_ofs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wen_ni || !ld_act) |=> ($stable(empty_ofs_o) && $stable(full_ofs_o)));

  a_r8_enable_mode_no_ofs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_mode_i |=> ($stable(empty_ofs_o) && $stable(full_ofs_o) && $stable(rd_data_o)));

  a_r6_rd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ren1_ni || ren2_ni || !ld_act) |=> $stable(rd_data_o));

  a_r7_rd_hold_on_coll: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_act && !wen_ni && !ren1_ni && !ren2_ni) |=> ($stable(rd_data_o) && coll_err_o));

  a_r7_err_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coll_err_o |-> $past(ld_act && !wen_ni && !ren1_ni && !ren2_ni));

  a_r4_rd_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[DATA_W-1:LO_W] == '0);
endmodule

bind ofs_loader ofs_loader_chk #(.OW(OW), .LO_W(LO_W), .DATA_W(DATA_W)) u_chk (
  .clk_i, .rst_ni, .shared_ctl_i, .wen_ni, .ren1_ni, .ren2_ni,
  .fifo_we_o, .fifo_re_o, .rd_data_o, .empty_ofs_o, .full_ofs_o, .coll_err_o,
  .load_mode_i(load_mode)
);

// File: tb/ofs_loader_test.sv
module ofs_loader_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        shared = 1'b1, wen = 1'b1, r1 = 1'b1, r2 = 1'b1;
  logic [8:0]  din = '0;
  logic        we, re, err;
  logic [8:0]  rd;
  logic [10:0] e_ofs, f_ofs;
  int          n_chk = 0, n_fail = 0, cyc = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  ofs_loader uut (
    .clk_i(clk), .rst_ni(rst_n), .shared_ctl_i(shared), .wen_ni(wen),
    .ren1_ni(r1), .ren2_ni(r2), .data_i(din), .fifo_we_o(we), .fifo_re_o(re),
    .rd_data_o(rd), .empty_ofs_o(e_ofs), .full_ofs_o(f_ofs), .coll_err_o(err)
  );

  typedef struct packed {
    logic [3:0]  ctl;  // {wen, shared, ren1, ren2}, active low
    logic [8:0]  din;
    logic [10:0] e;
    logic [10:0] f;
    logic [8:0]  rd;
    logic        err;
  } vec_t;

  // load-mode walk from reset
  localparam vec_t VEC [14] = '{
    '{4'b0011, 9'h1A5, 11'h0A5, 11'h007, 9'h000, 1'b0},  // R3 EL
    '{4'b0011, 9'h1FE, 11'h6A5, 11'h007, 9'h000, 1'b0},  // R3 R4 EH truncated
    '{4'b0111, 9'h033, 11'h6A5, 11'h007, 9'h000, 1'b0},  // R5 fifo write
    '{4'b1011, 9'h055, 11'h6A5, 11'h007, 9'h000, 1'b0},  // R5 no-op
    '{4'b0011, 9'h03C, 11'h6A5, 11'h03C, 9'h000, 1'b0},  // R3 FL
    '{4'b0011, 9'h005, 11'h6A5, 11'h53C, 9'h000, 1'b0},  // R3 FH
    '{4'b0011, 9'h011, 11'h611, 11'h53C, 9'h000, 1'b0},  // R3 wrap
    '{4'b1000, 9'h000, 11'h611, 11'h53C, 9'h011, 1'b0},  // R6 EL
    '{4'b1000, 9'h000, 11'h611, 11'h53C, 9'h006, 1'b0},  // R6 R4 EH
    '{4'b0000, 9'h002, 11'h211, 11'h53C, 9'h006, 1'b1},  // R7 collision
    '{4'b1000, 9'h000, 11'h211, 11'h53C, 9'h03C, 1'b0},  // R6 R7 FL
    '{4'b1000, 9'h000, 11'h211, 11'h53C, 9'h005, 1'b0},  // R6 FH
    '{4'b1000, 9'h000, 11'h211, 11'h53C, 9'h011, 1'b0},  // R6 wrap
    '{4'b1111, 9'h000, 11'h211, 11'h53C, 9'h011, 1'b0}   // R6 hold
  };

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(logic mode_pin);
    @(negedge clk);
    rst_n = 1'b0; shared = mode_pin; wen = 1'b1; r1 = 1'b1; r2 = 1'b1; din = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1; shared = 1'b1;
  endtask

  task automatic drive(logic [3:0] ctl, logic [8:0] d);
    @(negedge clk);
    {wen, shared, r1, r2} = ctl;
    din = d;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      finish_run();
    end
  end

  initial begin
    // R1 R2: reset into load mode
    do_reset(1'b0);
    #1;
    chk("R1 empty_ofs", 16'(e_ofs), 16'h007);
    chk("R1 full_ofs", 16'(f_ofs), 16'h007);
    chk("R1 rd_data", 16'(rd), 16'h000);
    chk("R1 coll_err", 16'(err), 16'h0);

    // R1 R4: selector at EL after reset, EH reads as zero-padded 0
    drive(4'b1000, 9'h0);
    @(posedge clk); #1;
    chk("R1 R6 first read EL", 16'(rd), 16'h007);
    drive(4'b1000, 9'h0);
    @(posedge clk); #1;
    chk("R4 EH read", 16'(rd), 16'h000);
    // R9: load strobe blocks fifo read; without it fifo read passes
    drive(4'b1000, 9'h0); #1;
    chk("R9 fifo_re blocked", 16'(re), 16'h0);
    drive(4'b1100, 9'h0); #1;
    chk("R9 fifo_re passes", 16'(re), 16'h1);
    drive(4'b0111, 9'h0); #1;
    chk("R5 fifo_we", 16'(we), 16'h1);
    drive(4'b0011, 9'h0); #1;
    chk("R5 fifo_we blocked", 16'(we), 16'h0);
    drive(4'b1111, 9'h0);

    // vector walk, fresh load-mode reset
    do_reset(1'b0);
    foreach (VEC[i]) begin
      drive(VEC[i].ctl, VEC[i].din);
      @(posedge clk); #1;
      chk($sformatf("R3 vec%0d empty_ofs", i), 16'(e_ofs), 16'(VEC[i].e));
      chk($sformatf("R3 vec%0d full_ofs", i), 16'(f_ofs), 16'(VEC[i].f));
      chk($sformatf("R6 vec%0d rd_data", i), 16'(rd), 16'(VEC[i].rd));
      chk($sformatf("R7 vec%0d coll_err", i), 16'(err), 16'(VEC[i].err));
    end
    @(posedge clk); #1;
    chk("R7 err single pulse", 16'(err), 16'h0);

    // R2 R8: second-enable mode
    do_reset(1'b1);
    drive(4'b0000, 9'h0AA); #1;
    chk("R8 fifo_we shared low", 16'(we), 16'h0);
    chk("R8 fifo_re", 16'(re), 16'h1);
    @(posedge clk); #1;
    chk("R2 R8 empty_ofs kept", 16'(e_ofs), 16'h007);
    chk("R8 full_ofs kept", 16'(f_ofs), 16'h007);
    chk("R8 rd_data kept", 16'(rd), 16'h000);
    chk("R8 no coll", 16'(err), 16'h0);
    drive(4'b0111, 9'h0); #1;
    chk("R8 fifo_we second enable", 16'(we), 16'h1);
    drive(4'b1111, 9'h0);
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule